// File: doc/BRIEF.md
# Stipple and Block-Copy Pixel Engine

This block accelerates two drawing operations on a byte-per-pixel frame memory. It has a small write bus with two ports, stipple and blit, and both ports share one colour register. The bus address carries the command. When address bit 2 is clear, the write only loads the colour register. When address bit 2 is set, the write starts an operation whose destination pixel is taken from the address bits above bit 2.

A stipple operation paints the colour into up to 32 consecutive pixels, as selected by a 32-bit mask. A blit operation does one of two things with a run of 1 to 32 pixels: it fills the run with the colour, or it copies the run from a source pixel address.

The engine drives a single-port synchronous RAM by itself. That RAM has a read latency of one cycle. The engine raises `busy` until the last pixel is written. While `busy` is high, any further command write is stalled through `bus_ready`.

Top module: `stipcopy_engine`

## Requirements
- R1: After reset `busy` is low, `bus_ready` is high, and neither `ram_we` nor `ram_re` is asserted. No RAM strobe is ever asserted while `busy` is low.
- R2: A bus write with `bus_addr[2]`=0 on either port loads `bus_wdata[7:0]` as the colour. It produces no RAM access and does not raise `busy`.
- R3: A bus write with `bus_addr[2]`=1 starts a command. The command's destination pixel is `bus_addr[PIX_AW+2:3]`. `bus_sel_blit`=0 selects stipple and `bus_sel_blit`=1 selects blit.
- R4: In a stipple command, mask bit 31-i decides pixel destination+i, for i from 0 to 31. Only pixels whose bit is 1 receive the colour. Addresses wrap modulo 2^PIX_AW. `busy` stays high for exactly 32 cycles.
- R5: In a blit command, `bus_wdata[23:0]` is the source field and `bus_wdata[28:24]` is the length minus one. Bits 31:29 are ignored. When the source field is 0xFFFFFF, the command fills length pixels with the colour and `busy` lasts length cycles.
- R6: For any other source field, the blit copies length pixels from source+k to destination+k, with k rising from 0. Each pixel is read before it is written, so an overlapping run gives the result of a byte-by-byte ascending copy. The copy performs exactly length RAM reads and length RAM writes, and `busy` lasts 2×length cycles.
- R7: A read on either port returns zero, and `bus_ready` stays high.
- R8: While `busy` is high, a command write sees `bus_ready`=0 and is held. The command is accepted in the cycle after the current command finishes.
- R9: A colour write made while a command is running is accepted at once. It does not change the colour used by the running command, and the next command uses the new colour.
- R10: The RAM is never read and written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_sel_blit | input | 1 | 0 = stipple port, 1 = blit port |
| bus_addr | input | PIX_AW+3 | Bus byte address; bit 2 selects colour load or command start |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data (always zero) |
| bus_ready | output | 1 | Low while a command write is being held |
| busy | output | 1 | A command is in progress |
| ram_addr | output | PIX_AW | Pixel address to the frame RAM |
| ram_re | output | 1 | RAM read enable (data returns one cycle later) |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | Pixel written to RAM |
| ram_rdata | input | 8 | Pixel read from RAM |

## Verification
The cycles that are hardest to get right are those in which a bus write lands while a command is still stepping through pixels. A colour load can arrive in the middle of a stipple, and a second command can be presented before the first one ends. The bench starts a 32-cycle stipple and then issues a colour write followed by a fill on the very next bus cycles. It checks that `bus_ready` is high for the colour load and low for the fill. It then compares the frame memory with a model in which the stipple painted with the old colour and the fill painted with the new one. Overlapping forward and backward copies are checked against the same ascending-order model, which exposes any reordering of the read and write phases.

// File: rtl/stipcopy_pkg.sv
package stipcopy_pkg;
   localparam int WORD_W    = 32;
   localparam int PIX_W     = 8;
   localparam int RUN_MAX   = 32;
   localparam int CNT_W     = $clog2(RUN_MAX);
   localparam int SRC_W     = 24;
   localparam int LEN_LSB   = 24;
   localparam logic [SRC_W-1:0] FILL_KEY = '1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_STIP,
      ST_FILL,
      ST_CRD,
      ST_CWR
   } eng_state_t;
endpackage

// File: rtl/stipcopy_decode.sv
module stipcopy_decode
   import stipcopy_pkg::*;
#(
   parameter int PIX_AW = 20,
   localparam int BUS_AW = PIX_AW + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   input  logic              busy,
   output logic [PIX_W-1:0]  colour,
   output logic              start,
   output logic [PIX_AW-1:0] cmd_dst,
   output logic              bus_ready,
   output logic [WORD_W-1:0] bus_rdata
);
   logic exec_wr;
   logic unused_dec;

   assign exec_wr   = bus_wr && bus_addr[2];
   assign start     = exec_wr && !busy;
   assign bus_ready = !(exec_wr && busy);
   assign cmd_dst   = bus_addr[BUS_AW-1:3];
   assign bus_rdata = '0;
   assign unused_dec = ^{bus_rd, bus_addr[1:0], bus_wdata[WORD_W-1:PIX_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         colour <= '0;
      else if (bus_wr && !bus_addr[2])
         colour <= bus_wdata[PIX_W-1:0];
   end
endmodule

// File: rtl/stipcopy_seq.sv
module stipcopy_seq
   import stipcopy_pkg::*;
#(
   parameter int PIX_AW = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cmd_blit,
   input  logic [WORD_W-1:0] cmd_data,
   input  logic [PIX_AW-1:0] cmd_dst,
   input  logic [PIX_W-1:0]  colour,
   output logic              busy,
   output logic [PIX_AW-1:0] ram_addr,
   output logic              ram_re,
   output logic              ram_we,
   output logic [PIX_W-1:0]  ram_wdata,
   input  logic [PIX_W-1:0]  ram_rdata
);
   eng_state_t        state_q;
   logic [CNT_W-1:0]  cnt_q, last_q;
   logic [PIX_AW-1:0] dst_q, src_q;
   logic [WORD_W-1:0] mask_q;
   logic [PIX_W-1:0]  col_q;
   logic              run_end;
   logic              unused_seq;

   assign run_end    = (cnt_q == last_q);
   assign unused_seq = ^cmd_data[WORD_W-1:LEN_LSB+CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         last_q  <= '0;
         dst_q   <= '0;
         src_q   <= '0;
         mask_q  <= '0;
         col_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               dst_q <= cmd_dst;
               col_q <= colour;
               cnt_q <= '0;
               if (!cmd_blit) begin
                  mask_q  <= cmd_data;
                  last_q  <= CNT_W'(RUN_MAX - 1);
                  state_q <= ST_STIP;
               end else begin
                  last_q  <= cmd_data[LEN_LSB +: CNT_W];
                  src_q   <= cmd_data[PIX_AW-1:0];
                  state_q <= (cmd_data[SRC_W-1:0] == FILL_KEY) ? ST_FILL : ST_CRD;
               end
            end
            ST_STIP, ST_FILL: begin
               mask_q <= {mask_q[WORD_W-2:0], 1'b0};
               dst_q  <= dst_q + 1'b1;
               cnt_q  <= cnt_q + 1'b1;
               if (run_end) state_q <= ST_IDLE;
            end
            ST_CRD: begin
               src_q   <= src_q + 1'b1;
               state_q <= ST_CWR;
            end
            ST_CWR: begin
               dst_q   <= dst_q + 1'b1;
               cnt_q   <= cnt_q + 1'b1;
               state_q <= run_end ? ST_IDLE : ST_CRD;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy      = (state_q != ST_IDLE);
      ram_re    = (state_q == ST_CRD);
      ram_addr  = ram_re ? src_q : dst_q;
      ram_we    = ((state_q == ST_STIP) && mask_q[WORD_W-1]) ||
                  (state_q == ST_FILL) || (state_q == ST_CWR);
      ram_wdata = (state_q == ST_CWR) ? ram_rdata : col_q;
   end
endmodule

// File: rtl/stipcopy_engine.sv
module stipcopy_engine
   import stipcopy_pkg::*;
#(
   parameter int PIX_AW = 20,
   localparam int BUS_AW = PIX_AW + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_sel_blit,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              bus_ready,
   output logic              busy,
   output logic [PIX_AW-1:0] ram_addr,
   output logic              ram_re,
   output logic              ram_we,
   output logic [PIX_W-1:0]  ram_wdata,
   input  logic [PIX_W-1:0]  ram_rdata
);
   generate
      if (PIX_AW < 6 || PIX_AW > SRC_W) begin : g_bad_aw
         $error("stipcopy_engine: PIX_AW must lie in 6..24");
      end
   endgenerate

   logic [PIX_W-1:0]  colour;
   logic              start;
   logic [PIX_AW-1:0] cmd_dst;

   stipcopy_decode #(.PIX_AW(PIX_AW)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .busy      (busy),
      .colour    (colour),
      .start     (start),
      .cmd_dst   (cmd_dst),
      .bus_ready (bus_ready),
      .bus_rdata (bus_rdata)
   );

   stipcopy_seq #(.PIX_AW(PIX_AW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cmd_blit  (bus_sel_blit),
      .cmd_data  (bus_wdata),
      .cmd_dst   (cmd_dst),
      .colour    (colour),
      .busy      (busy),
      .ram_addr  (ram_addr),
      .ram_re    (ram_re),
      .ram_we    (ram_we),
      .ram_wdata (ram_wdata),
      .ram_rdata (ram_rdata)
   );
endmodule

// File: rtl/stipcopy_engine_chk.sv
module stipcopy_engine_chk #(
   parameter int PIX_AW = 20,
   localparam int BUS_AW = PIX_AW + 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              bus_sel_blit,
   input logic [BUS_AW-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              bus_ready,
   input logic              busy,
   input logic [PIX_AW-1:0] ram_addr,
   input logic              ram_re,
   input logic              ram_we,
   input logic [7:0]        ram_wdata,
   input logic [7:0]        ram_rdata
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(ram_we || ram_re)); // R1

   AST_ONE_RAM_OP: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && ram_re)); // R10

   AST_EXEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_wr && bus_addr[2]) |-> !bus_ready); // R8

   AST_START_FROM_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bus_wr && bus_addr[2] && bus_ready)); // R3

   AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |=> (ram_we && busy)); // R6

   AST_READ_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> (bus_rdata == 32'd0 && bus_ready)); // R7
endmodule

bind stipcopy_engine stipcopy_engine_chk #(.PIX_AW(PIX_AW)) u_chk (.*);

// File: tb/stipcopy_engine_test.sv
`timescale 1ns/1ps
module stipcopy_engine_test;
   localparam int AW = 12;
   localparam int N  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_sel_blit = 1'b0;
   logic [AW+2:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_ready, busy;
   logic [AW-1:0] ram_addr;
   logic          ram_re, ram_we;
   logic [7:0]    ram_wdata;
   logic [7:0]    ram_rdata = '0;

   logic [7:0] mem  [N];
   logic [7:0] refm [N];
   logic [7:0] ref_col;
   int total = 0, bad = 0;
   int re_cnt = 0, we_cnt = 0, clash_cnt = 0;

   always #10 clk = ~clk;

   stipcopy_engine #(.PIX_AW(AW)) uut (.*);

   always @(posedge clk) begin
      if (ram_we) begin mem[ram_addr] <= ram_wdata; we_cnt <= we_cnt + 1; end
      if (ram_re) begin ram_rdata <= mem[ram_addr]; re_cnt <= re_cnt + 1; end
      if (ram_we && ram_re) clash_cnt <= clash_cnt + 1;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input bit blit, input logic [AW+2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel_blit = blit; bus_addr = a; bus_wdata = d;
      while (!bus_ready) @(negedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   function automatic void m_stip(input int dst, input logic [31:0] m, input logic [7:0] c);
      for (int i = 0; i < 32; i++) if (m[31-i]) refm[(dst+i)%N] = c;
   endfunction

   function automatic void m_fill(input int dst, input int len, input logic [7:0] c);
      for (int i = 0; i < len; i++) refm[(dst+i)%N] = c;
   endfunction

   function automatic void m_copy(input int dst, input int src, input int len);
      for (int i = 0; i < len; i++) refm[(dst+i)%N] = refm[(src+i)%N];
   endfunction

   function automatic int mem_diff();
      int d = 0;
      for (int i = 0; i < N; i++) if (mem[i] !== refm[i]) d++;
      return d;
   endfunction

   task automatic wait_idle(output int n);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
   endtask

   task automatic set_colour(input bit blit, input logic [7:0] c);
      int w0 = we_cnt, r0 = re_cnt;
      bus_write(blit, {AW'($urandom), 1'b0, 2'($urandom)}, {24'($urandom), c});
      ref_col = c;
      @(negedge clk);
      chk(!busy && we_cnt == w0 && re_cnt == r0, "R2 colour load no RAM access",
          we_cnt - w0 + re_cnt - r0, 0);
   endtask

   task automatic do_stip(input int dst, input logic [31:0] m, input string tag);
      int n;
      bus_write(1'b0, {AW'(dst), 3'b100}, m);
      wait_idle(n);
      m_stip(dst, m, ref_col);
      chk(n == 32, {tag, " R4 busy cycles"}, n, 32);
      chk(mem_diff() == 0, {tag, " R4 R3 memory"}, mem_diff(), 0);
   endtask

   task automatic do_fill(input int dst, input int len, input string tag);
      int n;
      bus_write(1'b1, {AW'(dst), 3'b100}, {3'($urandom), 5'(len-1), 24'hFFFFFF});
      wait_idle(n);
      m_fill(dst, len, ref_col);
      chk(n == len, {tag, " R5 busy cycles"}, n, len);
      chk(mem_diff() == 0, {tag, " R5 memory"}, mem_diff(), 0);
   endtask

   task automatic do_copy(input int dst, input int src, input int len, input string tag);
      int n, r0, w0;
      r0 = re_cnt; w0 = we_cnt;
      bus_write(1'b1, {AW'(dst), 3'b100}, {3'($urandom), 5'(len-1), 24'(src)});
      wait_idle(n);
      m_copy(dst, src, len);
      chk(n == 2*len, {tag, " R6 busy cycles"}, n, 2*len);
      chk(re_cnt - r0 == len && we_cnt - w0 == len, {tag, " R6 access count"},
          re_cnt - r0, len);
      chk(mem_diff() == 0, {tag, " R6 memory"}, mem_diff(), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int n;
      void'($urandom(32'd7731));
      for (int i = 0; i < N; i++) begin mem[i] = 8'($urandom); refm[i] = mem[i]; end
      ref_col = 8'h00;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && bus_ready && !ram_we && !ram_re, "R1 reset state",
          {busy, bus_ready, ram_we, ram_re}, 4'b0100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && bus_ready, "R1 after release", {busy, bus_ready}, 2'b01);

      // R7: reads on both ports
      for (int p = 0; p < 2; p++) begin
         bus_rd = 1'b1; bus_sel_blit = p[0]; bus_addr = {AW'($urandom), 3'b100};
         #1 chk(bus_rdata == 0 && bus_ready, "R7 read zero", bus_rdata, 0);
         @(negedge clk); bus_rd = 1'b0;
         chk(!busy, "R7 read starts nothing", busy, 0);
      end

      set_colour(1'b0, 8'h5A);
      do_stip(100, 32'h8000_0001, "stip ends");              // R4 bit order
      do_stip(N-7, 32'hFFFF_FFFF, "stip wrap");              // R4 wrap
      do_stip(300, 32'h0000_0000, "stip empty");
      set_colour(1'b1, 8'hC3);
      do_fill(500, 1, "fill len1");                          // R5
      do_fill(600, 32, "fill len32");
      do_copy(900, 1200, 32, "copy disjoint");               // R6
      do_copy(205, 200, 32, "copy fwd overlap");
      do_copy(195, 200, 20, "copy back overlap");
      do_copy(77, 77, 5, "copy self");

      // R8 + R9: colour write and command write during a running stipple
      set_colour(1'b0, 8'h11);
      bus_write(1'b0, {AW'(1500), 3'b100}, 32'hF0F0_1234);
      bus_wr = 1'b1; bus_sel_blit = 1'b1; bus_addr = {AW'(3), 3'b000}; bus_wdata = 32'h0000_00EE;
      #1 chk(bus_ready, "R9 colour accepted while busy", bus_ready, 1);
      @(negedge clk);
      bus_addr = {AW'(1510), 3'b100}; bus_wdata = {3'b0, 5'd9, 24'hFFFFFF};
      #1 chk(!bus_ready && busy, "R8 command held while busy", bus_ready, 0);
      while (!bus_ready) @(negedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
      chk(busy, "R8 held command started", busy, 1);
      wait_idle(n);
      m_stip(1500, 32'hF0F0_1234, 8'h11);
      m_fill(1510, 10, 8'hEE);
      ref_col = 8'hEE;
      chk(mem_diff() == 0, "R9 R8 old colour then new colour", mem_diff(), 0);

      // constrained random mix
      for (int k = 0; k < 50; k++) begin
         int op = $urandom_range(0, 3);
         int d = $urandom_range(0, N-1);
         int s = $urandom_range(0, N-1);
         int l = $urandom_range(1, 32);
         if ($urandom_range(0, 3) == 0) s = (d + $urandom_range(0, 8) - 4 + N) % N;
         case (op)
            0: set_colour(1'($urandom), 8'($urandom));
            1: do_stip(d, $urandom, "rand stip");
            2: do_fill(d, l, "rand fill");
            default: do_copy(d, s, l, "rand copy");
         endcase
      end

      chk(clash_cnt == 0, "R10 no read+write cycle", clash_cnt, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule